// File: doc/BRIEF.md
# Parallel camera capture interface

This block sits between a parallel image sensor and a memory-writing engine. It samples the sensor's data bus and its two sync lines on the pixel clock. It keeps only the pixels that fall inside active lines of selected frames, and it packs those pixels into 32-bit words. The words leave on a valid/ready stream, together with single-cycle frame-start and frame-end pulses and a sticky overflow flag.

Several static configuration inputs set the capture. They choose how many data lines are in use (8, 10, 12 or 14), the level of each sync line that marks blanking, and the pixel-clock edge the sensor data is sampled on. They also set a decimation mode that keeps every frame, every second frame or one frame in four. The whole block runs in the pixel-clock domain. The falling-edge option is built by sampling on both clock edges and choosing one of the two samples.

Capture is gated by an enable input. After the enable goes high, nothing is emitted until the next frame boundary, so the stream never holds the tail of a frame. Once a frame is being captured, it runs to its end.

Top module: `cam_capture`

## Requirements
- R1: While reset is held and right after it is released, `out_valid`, `frame_start`, `frame_end` and `overflow` are all low.
- R2: When `cfg_rise` is 1, data and syncs are taken at the rising edge of `pix_clk`. When it is 0, they are taken at the falling edge.
- R3: A sample taken while `cam_hs` equals `cfg_hs_pol` is horizontal blanking and is discarded. A sample taken at the opposite level is pixel data.
- R4: `cam_vs` equal to `cfg_vs_pol` means vertical blanking, and no pixel is kept. A frame starts when a sample at the blanking level is followed by a sample at the valid level, and it ends on the reverse change.
- R5: With `cfg_width` = 0 (8 lines), only `cam_d[7:0]` is used. Four consecutive kept samples form one word, the first in bits [7:0], then [15:8], [23:16] and [31:24].
- R6: With `cfg_width` = 1, 2 or 3 (10, 12 or 14 lines), only the lowest 10, 12 or 14 bus bits are used. Each sample is zero-extended to 16 bits, and two samples form one word with the first in bits [15:0].
- R7: With `cfg_rate` = 0, every frame is captured. With `cfg_rate` = 1, every second frame is captured, starting with the first. With `cfg_rate` = 2 or 3, one frame in four is captured, starting with the first. Frames that are skipped produce no words and no pulses.
- R8: At the end of a captured frame, a partly filled word is emitted with its unused lanes set to zero. `frame_end` pulses for one cycle, in the same cycle the flushed word is first presented.
- R9: Capture begins only at a frame start that follows a blanking sample seen while `cfg_enable` is high. A frame already in progress when the enable rises is not captured. Taking the enable low resets the decimation count, so the first frame after re-enabling is captured.
- R10: `frame_start` pulses for exactly one cycle per captured frame and never in the same cycle as `frame_end`.
- R11: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` holds its value.
- R12: If a word completes while an earlier word is still waiting, the new word is dropped and `overflow` is set. `overflow` stays set until `ovf_clr` is pulsed, and a new overflow in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pix_clk | input | 1 | Pixel clock, the only clock of the block |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_enable | input | 1 | Capture enable |
| cfg_width | input | 2 | Active bus width: 0=8, 1=10, 2=12, 3=14 bits |
| cfg_hs_pol | input | 1 | Level of `cam_hs` that means horizontal blanking |
| cfg_vs_pol | input | 1 | Level of `cam_vs` that means vertical blanking |
| cfg_rise | input | 1 | 1 = sample on rising edge, 0 = on falling edge |
| cfg_rate | input | 2 | Decimation: 0 all, 1 every second, 2 or 3 one in four |
| cam_vs | input | 1 | Vertical sync from the sensor |
| cam_hs | input | 1 | Horizontal sync from the sensor |
| cam_d | input | BUS_W | Sensor data bus |
| out_data | output | 32 | Packed pixel word |
| out_valid | output | 1 | `out_data` holds a word |
| out_ready | input | 1 | Downstream accepts the word |
| frame_start | output | 1 | One-cycle pulse at the start of a captured frame |
| frame_end | output | 1 | One-cycle pulse at the end of a captured frame |
| overflow | output | 1 | Sticky flag: a word was dropped |
| ovf_clr | input | 1 | Clears `overflow` |

## Verification
The hardest condition to reach from the ports is a data bus whose value differs between the falling and the rising edge of the same pixel period. Only that condition proves that the edge selection picks the right sample. The sensor model therefore drives each pixel slot in two phases: one value that is stable around the falling edge, then a second value, XOR-ed with a fixed pattern, that is stable at the next rising edge. The expected words come from whichever phase the configured edge should see. Further directed sequences raise the enable partway through a frame, stall the output across several word completions, and flush frames whose sample count does not fill the last word.

// File: rtl/cam_pkg.sv
package cam_pkg;

  localparam int WORD_W    = 32;
  localparam int HALF_W    = 16;
  localparam int BYTE_W    = 8;
  localparam int LANES_N8  = WORD_W / BYTE_W;
  localparam int LANES_N16 = WORD_W / HALF_W;
  localparam int LANE_IW   = $clog2(LANES_N8);
  localparam int FCNT_W    = 2;

  typedef enum logic [1:0] {
    BW_8  = 2'd0,
    BW_10 = 2'd1,
    BW_12 = 2'd2,
    BW_14 = 2'd3
  } bus_width_e;

  typedef enum logic [1:0] {
    DEC_ALL   = 2'd0,
    DEC_HALF  = 2'd1,
    DEC_QTR   = 2'd2,
    DEC_QTR_B = 2'd3
  } decim_e;

  // Bits of the bus kept for a given width, zero-extended to a half word
  function automatic logic [HALF_W-1:0] width_mask(bus_width_e w);
    logic [HALF_W-1:0] m;
    case (w)
      BW_8:    m = 16'h00FF;
      BW_10:   m = 16'h03FF;
      BW_12:   m = 16'h0FFF;
      default: m = 16'h3FFF;
    endcase
    return m;
  endfunction

  // Frame count bits that must be zero for a frame to be taken
  function automatic logic [FCNT_W-1:0] decim_mask(decim_e r);
    logic [FCNT_W-1:0] m;
    case (r)
      DEC_ALL:  m = 2'b00;
      DEC_HALF: m = 2'b01;
      default:  m = 2'b11;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/cam_sampler.sv
module cam_sampler #(
  parameter int BUS_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_rise,
  input  logic             vs_in,
  input  logic             hs_in,
  input  logic [BUS_W-1:0] d_in,
  output logic             vs_o,
  output logic             hs_o,
  output logic [BUS_W-1:0] d_o
);

  logic             vs_r, hs_r, vs_f, hs_f;
  logic [BUS_W-1:0] d_r, d_f;

  // rising-edge capture
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vs_r <= 1'b0;
      hs_r <= 1'b0;
      d_r  <= '0;
    end else begin
      vs_r <= vs_in;
      hs_r <= hs_in;
      d_r  <= d_in;
    end
  end

  // falling-edge capture
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vs_f <= 1'b0;
      hs_f <= 1'b0;
      d_f  <= '0;
    end else begin
      vs_f <= vs_in;
      hs_f <= hs_in;
      d_f  <= d_in;
    end
  end

  always_comb begin
    if (sel_rise) begin
      vs_o = vs_r;
      hs_o = hs_r;
      d_o  = d_r;
    end else begin
      vs_o = vs_f;
      hs_o = hs_f;
      d_o  = d_f;
    end
  end

endmodule

// File: rtl/cam_frame_ctrl.sv
module cam_frame_ctrl
  import cam_pkg::*;
#(
  parameter int BUS_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  bus_width_e        width,
  input  decim_e            rate,
  input  logic              hs_pol,
  input  logic              vs_pol,
  input  logic              vs_s,
  input  logic              hs_s,
  input  logic [BUS_W-1:0]  d_s,
  output logic              pix_valid,
  output logic [HALF_W-1:0] pix_data,
  output logic              flush,
  output logic              sof
);

  logic              prev_vb_q, prev_vb_n;
  logic              armed_q, armed_n;
  logic              capt_q, capt_n;
  logic [FCNT_W-1:0] fcnt_q, fcnt_n;
  logic              pv_n, fl_n, sof_n;
  logic [HALF_W-1:0] pd_n;

  logic vblank, hblank, start_evt, end_evt, chosen, take;

  always_comb begin
    vblank    = (vs_s == vs_pol);
    hblank    = (hs_s == hs_pol);
    start_evt = prev_vb_q & ~vblank;
    end_evt   = ~prev_vb_q & vblank;
    chosen    = ((fcnt_q & decim_mask(rate)) == '0);
    take      = start_evt & armed_q & enable & chosen;

    prev_vb_n = vblank;

    if (!enable)     armed_n = 1'b0;
    else if (vblank) armed_n = 1'b1;
    else             armed_n = armed_q;

    if (!enable)                     fcnt_n = '0;
    else if (start_evt && armed_q)   fcnt_n = fcnt_q + 1'b1;
    else                             fcnt_n = fcnt_q;

    if (end_evt)   capt_n = 1'b0;
    else if (take) capt_n = 1'b1;
    else           capt_n = capt_q;

    pv_n  = (capt_q | take) & ~vblank & ~hblank;
    pd_n  = HALF_W'(d_s) & width_mask(width);
    fl_n  = end_evt & capt_q;
    sof_n = take;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_vb_q <= 1'b1;
      armed_q   <= 1'b0;
      capt_q    <= 1'b0;
      fcnt_q    <= '0;
      pix_valid <= 1'b0;
      pix_data  <= '0;
      flush     <= 1'b0;
      sof       <= 1'b0;
    end else begin
      prev_vb_q <= prev_vb_n;
      armed_q   <= armed_n;
      capt_q    <= capt_n;
      fcnt_q    <= fcnt_n;
      pix_valid <= pv_n;
      flush     <= fl_n;
      sof       <= sof_n;
      if (pv_n) pix_data <= pd_n;
    end
  end

endmodule

// File: rtl/cam_packer.sv
module cam_packer
  import cam_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  bus_width_e        width,
  input  logic              pix_valid,
  input  logic [HALF_W-1:0] pix_data,
  input  logic              flush,
  input  logic              sof,
  input  logic              out_ready,
  input  logic              ovf_clr,
  output logic [WORD_W-1:0] out_data,
  output logic              out_valid,
  output logic              overflow,
  output logic              frame_start,
  output logic              frame_end
);

  logic [WORD_W-1:0]  acc_q, acc_n, merged, emit_word, od_n;
  logic [LANE_IW-1:0] idx_q, idx_n, last_idx;
  logic               narrow, word_done, flush_word, emit, slot_free;
  logic               ov_n, ovf_n;

  // place the incoming sample into its lane
  always_comb begin
    merged = acc_q;
    for (int i = 0; i < LANES_N8; i++) begin
      if (narrow && idx_q == LANE_IW'(i)) merged[i*BYTE_W +: BYTE_W] = pix_data[BYTE_W-1:0];
    end
    for (int j = 0; j < LANES_N16; j++) begin
      if (!narrow && idx_q[0] == j[0]) merged[j*HALF_W +: HALF_W] = pix_data;
    end
  end

  always_comb begin
    narrow     = (width == BW_8);
    last_idx   = narrow ? LANE_IW'(LANES_N8 - 1) : LANE_IW'(LANES_N16 - 1);
    word_done  = pix_valid & (idx_q >= last_idx);
    flush_word = flush & (idx_q != '0);
    emit       = word_done | flush_word;
    emit_word  = word_done ? merged : acc_q;
    slot_free  = ~out_valid | out_ready;

    if (pix_valid) begin
      acc_n = word_done ? '0 : merged;
      idx_n = word_done ? '0 : idx_q + 1'b1;
    end else if (flush) begin
      acc_n = '0;
      idx_n = '0;
    end else begin
      acc_n = acc_q;
      idx_n = idx_q;
    end

    if (emit && slot_free) begin
      ov_n = 1'b1;
      od_n = emit_word;
    end else begin
      ov_n = out_valid & ~out_ready;
      od_n = out_data;
    end

    if (emit && !slot_free) ovf_n = 1'b1;
    else if (ovf_clr)       ovf_n = 1'b0;
    else                    ovf_n = overflow;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q       <= '0;
      idx_q       <= '0;
      out_data    <= '0;
      out_valid   <= 1'b0;
      overflow    <= 1'b0;
      frame_start <= 1'b0;
      frame_end   <= 1'b0;
    end else begin
      acc_q       <= acc_n;
      idx_q       <= idx_n;
      out_data    <= od_n;
      out_valid   <= ov_n;
      overflow    <= ovf_n;
      frame_start <= sof;
      frame_end   <= flush;
    end
  end

endmodule

// File: rtl/cam_capture.sv
module cam_capture
  import cam_pkg::*;
#(
  parameter int BUS_W = 14
) (
  input  logic              pix_clk,
  input  logic              rst_n,
  input  logic              cfg_enable,
  input  logic [1:0]        cfg_width,
  input  logic              cfg_hs_pol,
  input  logic              cfg_vs_pol,
  input  logic              cfg_rise,
  input  logic [1:0]        cfg_rate,
  input  logic              cam_vs,
  input  logic              cam_hs,
  input  logic [BUS_W-1:0]  cam_d,
  output logic [WORD_W-1:0] out_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              frame_start,
  output logic              frame_end,
  output logic              overflow,
  input  logic              ovf_clr
);

  logic [1:0]        rst_pipe;
  logic              rst_core_n;
  logic              vs_s, hs_s;
  logic [BUS_W-1:0]  d_s;
  logic              pix_valid, flush, sof;
  logic [HALF_W-1:0] pix_data;
  bus_width_e        width;
  decim_e            rate;

  assign width = bus_width_e'(cfg_width);
  assign rate  = decim_e'(cfg_rate);

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge pix_clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  cam_sampler #(.BUS_W(BUS_W)) samp_i (
    .clk      (pix_clk),
    .rst_n    (rst_core_n),
    .sel_rise (cfg_rise),
    .vs_in    (cam_vs),
    .hs_in    (cam_hs),
    .d_in     (cam_d),
    .vs_o     (vs_s),
    .hs_o     (hs_s),
    .d_o      (d_s)
  );

  cam_frame_ctrl #(.BUS_W(BUS_W)) fctl_i (
    .clk       (pix_clk),
    .rst_n     (rst_core_n),
    .enable    (cfg_enable),
    .width     (width),
    .rate      (rate),
    .hs_pol    (cfg_hs_pol),
    .vs_pol    (cfg_vs_pol),
    .vs_s      (vs_s),
    .hs_s      (hs_s),
    .d_s       (d_s),
    .pix_valid (pix_valid),
    .pix_data  (pix_data),
    .flush     (flush),
    .sof       (sof)
  );

  cam_packer pack_i (
    .clk         (pix_clk),
    .rst_n       (rst_core_n),
    .width       (width),
    .pix_valid   (pix_valid),
    .pix_data    (pix_data),
    .flush       (flush),
    .sof         (sof),
    .out_ready   (out_ready),
    .ovf_clr     (ovf_clr),
    .out_data    (out_data),
    .out_valid   (out_valid),
    .overflow    (overflow),
    .frame_start (frame_start),
    .frame_end   (frame_end)
  );

endmodule

// File: rtl/cam_capture_chk.sv
module cam_capture_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] out_data,
  input logic        out_valid,
  input logic        out_ready,
  input logic        overflow,
  input logic        ovf_clr,
  input logic        frame_start,
  input logic        frame_end
);

  // R11
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  // R12
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow && !ovf_clr |=> overflow);

  // R12
  ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow) |-> $past(out_valid && !out_ready));

  // R10
  sof_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !frame_start);

  // R8
  eof_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> !frame_end);

  // R10
  sof_eof_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_start && frame_end));

endmodule

bind cam_capture cam_capture_chk chk_i (
  .clk         (pix_clk),
  .rst_n       (rst_n),
  .out_data    (out_data),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .overflow    (overflow),
  .ovf_clr     (ovf_clr),
  .frame_start (frame_start),
  .frame_end   (frame_end)
);

// File: tb/cam_capture_tb_top.sv
`timescale 1ns/1ps
module cam_capture_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_enable, cfg_hs_pol, cfg_vs_pol, cfg_rise, ovf_clr, out_ready;
  logic [1:0]  cfg_width, cfg_rate;
  logic        cam_vs, cam_hs;
  logic [13:0] cam_d;
  logic [31:0] out_data;
  logic        out_valid, frame_start, frame_end, overflow;

  always #10 clk = ~clk;

  cam_capture dut_i (
    .pix_clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_width(cfg_width),
    .cfg_hs_pol(cfg_hs_pol), .cfg_vs_pol(cfg_vs_pol), .cfg_rise(cfg_rise),
    .cfg_rate(cfg_rate), .cam_vs(cam_vs), .cam_hs(cam_hs), .cam_d(cam_d),
    .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
    .frame_start(frame_start), .frame_end(frame_end), .overflow(overflow),
    .ovf_clr(ovf_clr)
  );

  typedef struct packed {
    logic [1:0] w;
    logic       hsp;
    logic       vsp;
    logic       rise;
    logic [1:0] rate;
    logic [3:0] nfr;
    logic [3:0] lines;
    logic [3:0] pix;
    logic [3:0] expfr;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 1'b1, 1'b1, 1'b1, 2'd0, 4'd2, 4'd2, 4'd6, 4'd2},
    '{2'd0, 1'b0, 1'b0, 1'b0, 2'd0, 4'd2, 4'd3, 4'd3, 4'd2},
    '{2'd1, 1'b1, 1'b0, 1'b1, 2'd0, 4'd1, 4'd2, 4'd3, 4'd1},
    '{2'd2, 1'b0, 1'b1, 1'b0, 2'd0, 4'd1, 4'd1, 4'd5, 4'd1},
    '{2'd3, 1'b1, 1'b1, 1'b1, 2'd0, 4'd2, 4'd2, 4'd4, 4'd2},
    '{2'd0, 1'b0, 1'b1, 1'b1, 2'd1, 4'd5, 4'd1, 4'd4, 4'd3},
    '{2'd3, 1'b1, 1'b0, 1'b0, 2'd2, 4'd6, 4'd1, 4'd2, 4'd2},
    '{2'd0, 1'b1, 1'b1, 1'b0, 2'd3, 4'd5, 4'd1, 4'd4, 4'd2}
  };

  int          n_chk = 0, n_bad = 0, fs_cnt = 0, fe_cnt = 0;
  bit          finished = 1'b0;
  logic [31:0] exp_q[$];
  logic [31:0] got_q[$];
  logic [15:0] samp_q[$];

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // observer, away from the active edge
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      if (out_valid && out_ready) got_q.push_back(out_data);
      if (frame_start) fs_cnt++;
      if (frame_end)   fe_cnt++;
    end
  end

  function automatic logic [13:0] pix_early(int f, int l, int c);
    return 14'((f * 97 + l * 29 + c * 7 + 5) * 13);
  endfunction

  function automatic logic [15:0] keep_bits(logic [13:0] v);
    case (cfg_width)
      2'd0:    return {8'h00, v[7:0]};
      2'd1:    return {6'h00, v[9:0]};
      2'd2:    return {4'h0, v[11:0]};
      default: return {2'h0, v};
    endcase
  endfunction

  // one pixel period: early phase seen by the falling edge, late by the rising edge
  task automatic slot(input bit vvalid, input bit hvalid, input logic [13:0] e, input logic [13:0] la);
    @(posedge clk);
    #5;
    cam_vs = vvalid ? ~cfg_vs_pol : cfg_vs_pol;
    cam_hs = hvalid ? ~cfg_hs_pol : cfg_hs_pol;
    cam_d  = e;
    #10;
    cam_d  = la;
  endtask

  task automatic blank(input int n);
    for (int i = 0; i < n; i++) slot(1'b0, 1'b0, 14'h3C3C, 14'h0F0F);
  endtask

  task automatic pack_samples();
    logic [31:0] word = '0;
    int          k = 0;
    int          lanes = (cfg_width == 2'd0) ? 4 : 2;
    foreach (samp_q[i]) begin
      if (cfg_width == 2'd0) word = word | (32'(samp_q[i][7:0]) << (8 * k));
      else                   word = word | (32'(samp_q[i]) << (16 * k));
      k++;
      if (k == lanes) begin
        exp_q.push_back(word);
        word = '0;
        k = 0;
      end
    end
    if (k != 0) exp_q.push_back(word);
  endtask

  task automatic run_frame(input int f, input int lines, input int pix, input bit capt, input int en_line);
    samp_q.delete();
    blank(3);
    for (int l = 0; l < lines; l++) begin
      slot(1'b1, 1'b0, 14'h2AAA, 14'h1555);
      slot(1'b1, 1'b0, 14'h2AAA, 14'h1555);
      for (int c = 0; c < pix; c++) begin
        logic [13:0] e, la;
        if (l == en_line && c == 0) cfg_enable = 1'b1;
        e  = pix_early(f, l, c);
        la = e ^ 14'h2A55;
        slot(1'b1, 1'b1, e, la);
        if (capt) samp_q.push_back(keep_bits(cfg_rise ? la : e));
      end
      slot(1'b1, 1'b0, 14'h2AAA, 14'h1555);
    end
    if (capt) pack_samples();
  endtask

  task automatic compare(input int expfr, input string tag);
    check(got_q.size() == exp_q.size(), {tag, " R5 R6 R8 word count"}, 32'(got_q.size()), 32'(exp_q.size()));
    foreach (exp_q[i]) begin
      if (i < got_q.size())
        check(got_q[i] == exp_q[i], {tag, " R2 R3 R4 R5 R6 R8 word data"}, got_q[i], exp_q[i]);
    end
    check(fs_cnt == expfr, {tag, " R7 R10 frame_start count"}, 32'(fs_cnt), 32'(expfr));
    check(fe_cnt == expfr, {tag, " R7 R8 frame_end count"}, 32'(fe_cnt), 32'(expfr));
  endtask

  task automatic clear_obs();
    exp_q.delete();
    got_q.delete();
    fs_cnt = 0;
    fe_cnt = 0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    rst_n = 1'b0;
    cfg_enable = 1'b0; cfg_width = 2'd0; cfg_hs_pol = 1'b1; cfg_vs_pol = 1'b1;
    cfg_rise = 1'b1; cfg_rate = 2'd0; ovf_clr = 1'b0; out_ready = 1'b1;
    cam_vs = 1'b1; cam_hs = 1'b1; cam_d = '0;
    repeat (3) @(posedge clk);
    #5 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check(out_valid == 1'b0, "R1 out_valid after reset", 32'(out_valid), 0);
    check(frame_start == 1'b0, "R1 frame_start after reset", 32'(frame_start), 0);
    check(frame_end == 1'b0, "R1 frame_end after reset", 32'(frame_end), 0);
    check(overflow == 1'b0, "R1 overflow after reset", 32'(overflow), 0);

    // table-driven vectors
    for (int v = 0; v < NV; v++) begin
      int div;
      cfg_enable = 1'b0;
      cfg_width  = VECS[v].w;
      cfg_hs_pol = VECS[v].hsp;
      cfg_vs_pol = VECS[v].vsp;
      cfg_rise   = VECS[v].rise;
      cfg_rate   = VECS[v].rate;
      blank(4);
      clear_obs();
      cfg_enable = 1'b1;
      blank(2);
      div = (VECS[v].rate == 2'd0) ? 1 : (VECS[v].rate == 2'd1) ? 2 : 4;
      for (int f = 0; f < int'(VECS[v].nfr); f++)
        run_frame(f + v * 16, int'(VECS[v].lines), int'(VECS[v].pix), (f % div) == 0, -1);
      blank(10);
      compare(int'(VECS[v].expfr), $sformatf("vec%0d", v));
    end

    // R9: enable rises mid-frame; disable resets the decimation count
    cfg_enable = 1'b0; cfg_width = 2'd0; cfg_hs_pol = 1'b1; cfg_vs_pol = 1'b1;
    cfg_rise = 1'b1; cfg_rate = 2'd1;
    blank(4);
    clear_obs();
    run_frame(200, 2, 4, 1'b0, 1);
    run_frame(201, 2, 4, 1'b1, -1);
    run_frame(202, 2, 4, 1'b0, -1);
    cfg_enable = 1'b0;
    blank(3);
    cfg_enable = 1'b1;
    blank(2);
    run_frame(203, 2, 4, 1'b1, -1);
    blank(10);
    compare(2, "R9 arming");

    // R11: stalled output holds its word
    cfg_enable = 1'b0; cfg_width = 2'd3; cfg_rate = 2'd0;
    blank(4);
    clear_obs();
    out_ready = 1'b0;
    cfg_enable = 1'b1;
    blank(2);
    run_frame(300, 1, 2, 1'b1, -1);
    blank(6);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(out_valid == 1'b1, "R11 valid held while stalled", 32'(out_valid), 1);
      check(out_data == exp_q[0], "R11 data held while stalled", out_data, exp_q[0]);
    end
    @(posedge clk); #5 out_ready = 1'b1;
    blank(4);
    check(got_q.size() == 1, "R11 word delivered after stall", 32'(got_q.size()), 1);
    if (got_q.size() > 0) check(got_q[0] == exp_q[0], "R11 delivered word", got_q[0], exp_q[0]);
    check(overflow == 1'b0, "R11 no overflow for a single word", 32'(overflow), 0);

    // R12: overflow drops new words, sticky until cleared
    clear_obs();
    out_ready = 1'b0;
    run_frame(400, 1, 6, 1'b1, -1);
    blank(4);
    check(overflow == 1'b1, "R12 overflow set", 32'(overflow), 1);
    @(posedge clk); #5 out_ready = 1'b1;
    blank(4);
    check(got_q.size() == 1, "R12 later words dropped", 32'(got_q.size()), 1);
    if (got_q.size() > 0) check(got_q[0] == exp_q[0], "R12 first word kept", got_q[0], exp_q[0]);
    check(overflow == 1'b1, "R12 overflow sticky", 32'(overflow), 1);
    @(posedge clk); #5 ovf_clr = 1'b1;
    @(posedge clk); #5 ovf_clr = 1'b0;
    @(negedge clk);
    check(overflow == 1'b0, "R12 overflow cleared", 32'(overflow), 0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule